// File: doc/BRIEF.md
# Power-Management Register Access Channel

This block is one host-facing channel for reaching the 16-bit registers of an external power-management device through a shared serial backend. The host writes one command word that names the register (as a halfword address), says whether the access is a write, and carries the write data. The channel then raises a request toward the backend and waits for a grant. A write is finished as soon as the backend takes it. A read also waits for returned data, and then parks with that data on show until software acknowledges it with a valid-clear strobe.

The host watches the channel through one packed status word. The word holds the captured read data, the channel state code, a request-pending flag, a sync-idle flag, the init-done flag and a system-idle flag. Software sets the init-done flag through its own one-bit register at the end of bring-up. Commands issued while the channel is busy are dropped, so software polls for idle before it issues a new access.

Top module: `pmw_chan_top`

## Requirements
- R1: When a command is accepted, bit 31 of the command word (1 = write) drives `be_write`, bits 30:16 drive `be_addr`, and bits 15:0 drive `be_wdata`. These values stay on the backend pins while `be_req` is high.
- R2: The status word holds read data in bits 15:0, the state code in bits 18:16, request pending in bit 19, sync idle in bit 20, init done in bit 21 and system idle in bit 22. Bits 31:23 are zero.
- R3: The state codes are 0 for idle, 2 for request, 4 for waiting for read data and 6 for waiting for valid-clear.
- R4: A write command leaves the request state for idle (code 0) on the cycle after a clock edge where `be_gnt` is high.
- R5: A read command leaves the request state for code 4 when granted. It moves to code 6 on the edge where `be_rvalid` is high. Grants seen outside the request state have no effect, and so does read-data-valid seen outside state 4.
- R6: Read data is captured from `be_rdata` on that edge. It then stays unchanged in status bits 15:0 until the next read's data arrives, including after valid-clear.
- R7: In state 6 the channel stays put until `vldclr_we` is high with `vldclr_bit` = 1, and then returns to idle. A valid-clear write with a 0 is ignored.
- R8: A command written while the state is not idle is ignored. The backend address, data and direction of the transaction in flight are unchanged.
- R9: Request pending (bit 19) and `be_req` are high exactly while the state is the request state.
- R10: Sync idle (bit 20) is high whenever no request is outstanding toward the backend, that is in states 0 and 6.
- R11: Init done (bit 21) follows the last value written through `init_we`/`init_bit`. System idle (bit 22) is high exactly when the state is idle.
- R12: A synchronous active-high reset gives state idle, init done 0, read data 0 and `be_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word: write flag, halfword address, write data |
| vldclr_we | input | 1 | Valid-clear register write strobe |
| vldclr_bit | input | 1 | Value written to valid-clear (1 acknowledges) |
| init_we | input | 1 | Init-done register write strobe |
| init_bit | input | 1 | Value written to init-done |
| status | output | 32 | Packed status word |
| be_req | output | 1 | Request toward backend |
| be_write | output | 1 | Request direction, 1 = write |
| be_addr | output | 15 | Halfword register address |
| be_wdata | output | 16 | Write data |
| be_gnt | input | 1 | Backend has taken the request |
| be_rvalid | input | 1 | Backend read data valid |
| be_rdata | input | 16 | Backend read data |

## Verification
The bench builds the block with its default widths: 16-bit data, a 32-bit command word (which leaves a 15-bit address) and a 32-bit status word. With these widths every status bit position named in R2 can be checked exactly. They also let addresses with the top and bottom address bits set travel through to the backend pins. A behavioural model is stepped alongside the design and compared each cycle. The stimulus covers delayed grants, stray grant and valid strobes, zero-valued clears, commands issued in every busy state, and a reset in the middle of a read.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd2,
        ST_WRD  = 3'd4,
        ST_WVC  = 3'd6
    } chan_state_e;

    typedef struct packed {
        chan_state_e state;
        logic        is_wr;
    } fsm_regs_t;
endpackage

// File: rtl/pmw_chan_fsm.sv
module pmw_chan_fsm
    import pmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic        cmd_wr_flag,
    input  logic        vldclr_we,
    input  logic        vldclr_bit,
    input  logic        be_gnt,
    input  logic        be_rvalid,
    output logic        cmd_take,
    output logic        rd_cap,
    output logic        req_out,
    output logic        cur_wr,
    output chan_state_e state_o
);
    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        cmd_take = 1'b0;
        rd_cap   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: if (cmd_we) begin
                cmd_take  = 1'b1;
                r_d.state = ST_REQ;
                r_d.is_wr = cmd_wr_flag;
            end
            ST_REQ: if (be_gnt) r_d.state = r_q.is_wr ? ST_IDLE : ST_WRD;
            ST_WRD: if (be_rvalid) begin
                rd_cap    = 1'b1;
                r_d.state = ST_WVC;
            end
            ST_WVC: if (vldclr_we && vldclr_bit) r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_IDLE, is_wr: 1'b0};
        else     r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign req_out = (r_q.state == ST_REQ);
    assign cur_wr  = r_q.is_wr;

    a_r4_write_done: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_REQ && be_gnt && cur_wr) |=> state_o == ST_IDLE);
    a_r5_read_grant: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_REQ && be_gnt && !cur_wr) |=> state_o == ST_WRD);
    a_r7_park: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WVC && !(vldclr_we && vldclr_bit)) |=> state_o == ST_WVC);
    a_r3_legal_code: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_IDLE || state_o == ST_REQ || state_o == ST_WRD || state_o == ST_WVC);
endmodule

// File: rtl/pmw_cmd_latch.sv
module pmw_cmd_latch #(
    parameter int CMD_W  = 32,
    parameter int DATA_W = 16,
    localparam int ADDR_W = CMD_W - 1 - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;

    always_comb begin
        addr_d  = addr_q;
        wdata_d = wdata_q;
        if (take) begin
            addr_d  = cmd_word[CMD_W-2:DATA_W];
            wdata_d = cmd_word[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    assign addr  = addr_q;
    assign wdata = wdata_q;

    a_r8_hold_cmd: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(addr) && $stable(wdata)));
endmodule

// File: rtl/pmw_rd_hold.sv
module pmw_rd_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_q, data_d;

    always_comb begin
        data_d = cap ? din : data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= data_d;
    end

    assign dout = data_q;

    a_r6_stable: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(dout));
endmodule

// File: rtl/pmw_chan_top.sv
module pmw_chan_top
    import pmw_pkg::*;
#(
    parameter int CMD_W  = 32,
    parameter int DATA_W = 16,
    parameter int STAT_W = 32,
    localparam int ADDR_W   = CMD_W - 1 - DATA_W,
    localparam int ST_LSB   = DATA_W,
    localparam int REQ_BIT  = DATA_W + 3,
    localparam int SYNC_BIT = DATA_W + 4,
    localparam int INIT_BIT = DATA_W + 5,
    localparam int SYS_BIT  = DATA_W + 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              vldclr_we,
    input  logic              vldclr_bit,
    input  logic              init_we,
    input  logic              init_bit,
    output logic [STAT_W-1:0] status,
    output logic              be_req,
    output logic              be_write,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_gnt,
    input  logic              be_rvalid,
    input  logic [DATA_W-1:0] be_rdata
);
    chan_state_e       state;
    logic              take, cap;
    logic [DATA_W-1:0] rd_data;
    logic              init_q, init_d;

    pmw_chan_fsm u_fsm (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wr_flag(cmd_word[CMD_W-1]),
        .vldclr_we(vldclr_we), .vldclr_bit(vldclr_bit), .be_gnt(be_gnt),
        .be_rvalid(be_rvalid), .cmd_take(take), .rd_cap(cap), .req_out(be_req),
        .cur_wr(be_write), .state_o(state)
    );

    pmw_cmd_latch #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_cmd (
        .clk(clk), .rst(rst), .take(take), .cmd_word(cmd_word),
        .addr(be_addr), .wdata(be_wdata)
    );

    pmw_rd_hold #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .cap(cap), .din(be_rdata), .dout(rd_data)
    );

    always_comb begin
        init_d = init_we ? init_bit : init_q;
    end

    always_ff @(posedge clk) begin
        if (rst) init_q <= 1'b0;
        else     init_q <= init_d;
    end

    always_comb begin
        status                     = '0;
        status[DATA_W-1:0]         = rd_data;
        status[ST_LSB+2:ST_LSB]    = state;
        status[REQ_BIT]            = (state == ST_REQ);
        status[SYNC_BIT]           = (state == ST_IDLE) || (state == ST_WVC);
        status[INIT_BIT]           = init_q;
        status[SYS_BIT]            = (state == ST_IDLE);
    end

    a_r9_req_not_sync: assert property (@(posedge clk) disable iff (rst)
        be_req |-> !status[SYNC_BIT]);
    a_r11_init_follow: assert property (@(posedge clk) disable iff (rst)
        init_we |=> status[INIT_BIT] == $past(init_bit));
endmodule

// File: tb/tb_pmw_chan_top.sv
`timescale 1ns/1ps
module tb_pmw_chan_top;
    logic        clk = 0, rst = 1;
    logic        cmd_we = 0, vldclr_we = 0, vldclr_bit = 0, init_we = 0, init_bit = 0;
    logic [31:0] cmd_word = 0;
    logic        be_gnt = 0, be_rvalid = 0;
    logic [15:0] be_rdata = 0;
    logic [31:0] status;
    logic        be_req, be_write;
    logic [14:0] be_addr;
    logic [15:0] be_wdata;

    int tests = 0, fails = 0;
    int m_state = 0, m_wr = 0, m_addr = 0, m_wdata = 0, m_rd = 0, m_init = 0;

    always #2 clk = ~clk;

    pmw_chan_top dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .vldclr_we(vldclr_we), .vldclr_bit(vldclr_bit), .init_we(init_we),
        .init_bit(init_bit), .status(status), .be_req(be_req), .be_write(be_write),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_gnt(be_gnt),
        .be_rvalid(be_rvalid), .be_rdata(be_rdata)
    );

    task automatic check(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        check("R6 read data", status[15:0], m_rd);
        check("R3 state code", status[18:16], m_state);
        check("R9 pending", status[19], m_state == 2);
        check("R10 sync idle", status[20], (m_state == 0) || (m_state == 6));
        check("R11 init done", status[21], m_init);
        check("R11 sys idle", status[22], m_state == 0);
        check("R2 upper zero", status[31:23], 0);
        check("R9 be_req", be_req, m_state == 2);
        if (m_state == 2) begin
            check("R1 be_write", be_write, m_wr);
            check("R1 be_addr", be_addr, m_addr);
            check("R1 be_wdata", be_wdata, m_wdata);
        end
    endtask

    // one clock: inputs held across the edge, model stepped, outputs compared at the falling edge
    task automatic tick(bit cwe, logic [31:0] cw, bit vwe, bit vb, bit iwe, bit ib,
                        bit g, bit rv, logic [15:0] rdat);
        int ns, nwr, na, nd, nrd, ni;
        cmd_we = cwe; cmd_word = cw; vldclr_we = vwe; vldclr_bit = vb;
        init_we = iwe; init_bit = ib; be_gnt = g; be_rvalid = rv; be_rdata = rdat;
        ns = m_state; nwr = m_wr; na = m_addr; nd = m_wdata; nrd = m_rd; ni = m_init;
        if (rst) begin
            ns = 0; nwr = 0; na = 0; nd = 0; nrd = 0; ni = 0;
        end else begin
            case (m_state)
                0: if (cwe) begin ns = 2; nwr = cw[31]; na = cw[30:16]; nd = cw[15:0]; end
                2: if (g) ns = m_wr ? 0 : 4;
                4: if (rv) begin nrd = rdat; ns = 6; end
                6: if (vwe && vb) ns = 0;
                default: ns = 0;
            endcase
            if (iwe) ni = ib;
        end
        @(posedge clk);
        m_state = ns; m_wr = nwr; m_addr = na; m_wdata = nd; m_rd = nrd; m_init = ni;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(2);
        rst = 0;
        // R12 reset state
        check("R12 reset status", status, 32'h0050_0000);
        // R4 write, immediate grant; R1 fields incl. top and bottom address bits
        tick(1, {1'b1, 15'h4001, 16'hA55A}, 0, 0, 0, 0, 0, 0, 0);
        check("R1 addr passes", be_addr, 15'h4001);
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R4 write back idle", status[18:16], 0);
        // R5 stray grant and valid in idle ignored
        tick(0, 0, 0, 0, 0, 0, 1, 1, 16'h1234);
        check("R5 stray ignored", status[18:0], 0);
        // R8 write with delayed grant, commands during REQ ignored
        tick(1, {1'b1, 15'h005E, 16'h0050}, 0, 0, 0, 0, 0, 0, 0);
        tick(1, {1'b0, 15'h7FFF, 16'hFFFF}, 0, 0, 0, 0, 0, 0, 0);
        check("R8 addr kept", be_addr, 15'h005E);
        idle(3);
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        // R5 read path with R6 data capture
        tick(1, {1'b0, 15'h5E05, 16'h0}, 0, 0, 0, 0, 0, 0, 0);
        idle(2);
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R5 wait data", status[18:16], 4);
        tick(1, {1'b1, 15'h1111, 16'h2222}, 0, 0, 0, 0, 0, 0, 16'hBEEF);
        idle(2);
        tick(0, 0, 0, 0, 0, 0, 0, 1, 16'h5AA5);
        check("R6 captured", status[15:0], 16'h5AA5);
        // R7 zero clear ignored, command and strays ignored in state 6
        tick(0, 0, 1, 0, 0, 0, 1, 1, 16'h0BAD);
        tick(1, {1'b1, 15'h2222, 16'h3333}, 0, 0, 0, 0, 0, 0, 0);
        check("R7 parked", status[18:16], 6);
        check("R6 held", status[15:0], 16'h5AA5);
        tick(0, 0, 1, 1, 0, 0, 0, 0, 0);
        check("R7 cleared", status[18:16], 0);
        check("R6 kept after clear", status[15:0], 16'h5AA5);
        // R11 init done set, R10 sync
        tick(0, 0, 0, 0, 1, 1, 0, 0, 0);
        check("R11 init set", status[21], 1);
        // second read, immediate grant and data
        tick(1, {1'b0, 15'h0001, 16'h0}, 0, 0, 0, 0, 1, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 0, 1, 16'hC3C3);
        check("R10 sync in wvc", status[20], 1);
        tick(0, 0, 1, 1, 0, 0, 0, 0, 0);
        // R12 reset mid-read
        tick(1, {1'b0, 15'h0002, 16'h0}, 0, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        rst = 1;
        idle(1);
        rst = 0;
        check("R12 mid-read reset", status, 32'h0050_0000);
        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule